// File: doc/BRIEF.md
# Dual-Bank Concurrent Refresh Scheduler

This block schedules distributed refresh for one vault of a stacked DRAM. A down-counter sets the pace. Its period is the retention window divided by the number of refresh commands per window. When the temperature flag shows hot operation, the window is halved. Each refresh command covers one bundle of rows.

In dual-bank mode a bundle is split into two subgroups held in a pair of adjacent banks. Both subgroups refresh at the same time. Within each bank the subgroup holds one row from every subarray, at the bank's current local row pointer, so the whole subgroup takes one row time. The pairs take their turns in rotation. Only two banks are ever busy together, which caps peak refresh current.

A per-bank mode is also provided for comparison. In that mode one bank takes the whole bundle and refreshes its rows one after another. Read and write requests to a bank under refresh are stalled. If a refresh comes due while the previous one is still running, a pending flag records it.

Top module: `rfsh_dual_bank_sched`

## Requirements
- R1: With default parameters (8 banks, 4 subarrays, 8 local rows per subarray, normal window 2048 cycles, 32 commands per window), consecutive refresh strobes are 64 cycles apart when `temp_hot` is low and 32 cycles apart when it is high, provided no refresh is still busy when one comes due.
- R2: On the first clock edge that samples `temp_hot` high after it was low, the interval counter reloads with the hot interval. The next strobe appears at the 32nd clock edge after that edge.
- R3: In dual-bank mode (`mode_dual`=1) each command refreshes banks 2p and 2p+1, with p rotating 0,1,2,3,0,...: `grp_a_bank`=2p, `grp_b_bank`=2p+1, and `grp_b_valid`=1 while busy. After reset the first dual command uses pair 0.
- R4: In dual-bank mode both subgroups cover all subarrays in parallel. `grp_a_sa_mask` and `grp_b_sa_mask` are all ones. Each row output equals that bank's local row pointer. Both banks stay busy for exactly `row_cycles` cycles (0 counts as 1).
- R5: No bank other than the selected ones is ever busy. `busy_mask` has exactly two bits set in dual-bank mode and one bit in per-bank mode, and it is zero when idle.
- R6: In per-bank mode (`mode_dual`=0) banks rotate 0..7. The bundle covers local rows ptr and ptr+1 of the chosen bank, one row at a time, in this order: subarrays 0..3 at ptr, then subarrays 0..3 at ptr+1. Each row lasts `row_cycles` cycles. `grp_a_sa_mask` is one-hot, with bit s meaning subarray s. The bank is busy for 8 x `row_cycles` cycles and `grp_b_valid`=0.
- R7: Each bank's local row pointer advances by 1 per dual command and by 2 per per-bank command that includes it. It wraps modulo 8, so every row of every bank is visited once per window.
- R8: `req_stall` is 1 exactly when `req_valid` is 1 and `req_bank` is a bank currently under refresh.
- R9: A refresh that comes due while a refresh is busy raises `refresh_pending`. When the busy refresh finishes, the next one starts after exactly one idle cycle, and `refresh_pending` is 0 in its strobe cycle.
- R10: `refresh_strobe` is a single-cycle pulse in the first busy cycle of each command. `mode_dual` and `row_cycles` are captured at that start and held for the whole command.
- R11: After reset, `busy_mask`, `refresh_strobe`, `refresh_pending`, `grp_b_valid` and `req_stall` are 0, and all row pointers start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_hot | input | 1 | High-temperature flag; halves the retention window |
| mode_dual | input | 1 | 1 selects dual-bank concurrent refresh, 0 selects per-bank sequential |
| row_cycles | input | 8 | Cycles per row refresh time |
| req_valid | input | 1 | A read or write request is offered |
| req_bank | input | 3 | Bank targeted by the request |
| req_stall | output | 1 | Request must wait because its bank is refreshing |
| busy_mask | output | 8 | One bit per bank under refresh |
| refresh_strobe | output | 1 | One-cycle pulse at the start of each refresh command |
| refresh_pending | output | 1 | A refresh came due while one was in progress |
| grp_a_bank | output | 3 | Bank of the first subgroup |
| grp_a_row | output | 3 | Local row of the first subgroup |
| grp_a_sa_mask | output | 4 | Subarrays of the first subgroup being refreshed |
| grp_b_valid | output | 1 | Second subgroup active (dual-bank command busy) |
| grp_b_bank | output | 3 | Bank of the second subgroup |
| grp_b_row | output | 3 | Local row of the second subgroup |
| grp_b_sa_mask | output | 4 | Subarrays of the second subgroup being refreshed |

## Verification
The bench runs more than a full window of dual commands, so the row pointers wrap. A design that wrapped early or advanced only one bank of a pair would show wrong row numbers on the second pass. It then switches to per-bank mode and back. The per-bank and dual pointers must stay in step, and the subarray walk inside a per-bank bundle is checked cycle by cycle; an off-by-one in the row timer would show up as a shifted subarray mask.

The hot flag is raised in the middle of an interval. A design that waited for the current count to expire before reloading would produce its strobe tens of cycles late. Finally, a long per-bank refresh is set against the short hot interval. This exposes a scheduler that drops an overdue refresh or leaves extra idle cycles before serving it. Request stalls are compared every cycle against the banks the scoreboard expects to be busy.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int REFI_NORM = 64,
  parameter int REFI_HOT  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic temp_hot,
  output logic due
);
  localparam int CW = $clog2(REFI_NORM + 1);
  localparam logic [CW-1:0] LD_NORM = CW'(REFI_NORM - 1);
  localparam logic [CW-1:0] LD_HOT  = CW'(REFI_HOT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hot_q;
  logic          hot_rise;

  always_comb begin
    hot_rise = temp_hot & ~hot_q;
    due      = (cnt_q == '0) & ~hot_rise;
    if (hot_rise)
      cnt_d = LD_HOT;
    else if (cnt_q == '0)
      cnt_d = temp_hot ? LD_HOT : LD_NORM;
    else
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LD_NORM;
      hot_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hot_q <= temp_hot;
    end
  end
endmodule

// File: rtl/rfsh_busy_engine.sv
module rfsh_busy_engine
  import rfsh_pkg::*;
#(
  parameter int  SUBARRAYS = 4,
  parameter int  RCW       = 8,
  localparam int STEPW     = $clog2(2 * SUBARRAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             due,
  input  logic             mode_dual,
  input  logic [RCW-1:0]   row_cycles,
  output logic             busy,
  output logic             start,
  output logic             strobe,
  output logic             dual_q,
  output logic [STEPW-1:0] step,
  output logic             pending
);
  localparam logic [STEPW-1:0] LAST_PB = STEPW'(2 * SUBARRAYS - 1);

  eng_state_e       st_q, st_d;
  logic [RCW-1:0]   rc_q, rc_d, rtmr_q, rtmr_d, rc_eff;
  logic [STEPW-1:0] step_q, step_d, last_step;
  logic             dual_d, pend_q, pend_d, strobe_q;

  always_comb begin
    rc_eff    = (row_cycles == '0) ? RCW'(1) : row_cycles;
    last_step = dual_q ? '0 : LAST_PB;
    start     = (st_q == ENG_IDLE) && (due || pend_q);
    st_d      = st_q;
    rc_d      = rc_q;
    rtmr_d    = rtmr_q;
    step_d    = step_q;
    dual_d    = dual_q;
    pend_d    = pend_q;
    if (start) begin
      st_d   = ENG_BUSY;
      rc_d   = rc_eff;
      rtmr_d = rc_eff - 1'b1;
      step_d = '0;
      dual_d = mode_dual;
      pend_d = 1'b0;
    end else if (st_q == ENG_BUSY) begin
      if (due) pend_d = 1'b1;
      if (rtmr_q == '0) begin
        if (step_q == last_step) begin
          st_d = ENG_IDLE;
        end else begin
          step_d = step_q + 1'b1;
          rtmr_d = rc_q - 1'b1;
        end
      end else begin
        rtmr_d = rtmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ENG_IDLE;
      rc_q     <= '0;
      rtmr_q   <= '0;
      step_q   <= '0;
      dual_q   <= 1'b0;
      pend_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rc_q     <= rc_d;
      rtmr_q   <= rtmr_d;
      step_q   <= step_d;
      dual_q   <= dual_d;
      pend_q   <= pend_d;
      strobe_q <= start;
    end
  end

  assign busy    = (st_q == ENG_BUSY);
  assign strobe  = strobe_q;
  assign step    = step_q;
  assign pending = pend_q;
endmodule

// File: rtl/rfsh_bank_sequencer.sv
module rfsh_bank_sequencer #(
  parameter int  NUM_BANKS   = 8,
  parameter int  ROWS_PER_SA = 8,
  localparam int BW          = $clog2(NUM_BANKS),
  localparam int RW          = $clog2(ROWS_PER_SA),
  localparam int PW          = $clog2(NUM_BANKS / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_dual,
  output logic [BW-1:0] bank_a,
  output logic [BW-1:0] bank_b,
  output logic [RW-1:0] row_a,
  output logic [RW-1:0] row_b
);
  logic [PW-1:0] pidx_q, pidx_d;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [BW-1:0] sel_a, sel_b;
  logic [BW-1:0] bank_a_q, bank_a_d, bank_b_q, bank_b_d;
  logic [RW-1:0] row_a_q, row_a_d, row_b_q, row_b_d;
  logic [RW-1:0] rowptr_q [NUM_BANKS];
  logic [RW-1:0] rowptr_d [NUM_BANKS];

  always_comb begin
    sel_a    = mode_dual ? {pidx_q, 1'b0} : bidx_q;
    sel_b    = {pidx_q, 1'b1};
    pidx_d   = pidx_q;
    bidx_d   = bidx_q;
    bank_a_d = bank_a_q;
    bank_b_d = bank_b_q;
    row_a_d  = row_a_q;
    row_b_d  = row_b_q;
    if (start) begin
      bank_a_d = sel_a;
      bank_b_d = sel_b;
      row_a_d  = rowptr_q[sel_a];
      row_b_d  = rowptr_q[sel_b];
      if (mode_dual) pidx_d = pidx_q + 1'b1;
      else           bidx_d = bidx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ptr
    logic [RW-1:0] inc;
    always_comb begin
      inc = '0;
      if (start) begin
        if (mode_dual) begin
          if (PW'(g / 2) == pidx_q) inc = RW'(1);
        end else begin
          if (BW'(g) == bidx_q) inc = RW'(2);
        end
      end
      rowptr_d[g] = rowptr_q[g] + inc;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rowptr_q[g] <= '0;
      else        rowptr_q[g] <= rowptr_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidx_q   <= '0;
      bidx_q   <= '0;
      bank_a_q <= '0;
      bank_b_q <= '0;
      row_a_q  <= '0;
      row_b_q  <= '0;
    end else begin
      pidx_q   <= pidx_d;
      bidx_q   <= bidx_d;
      bank_a_q <= bank_a_d;
      bank_b_q <= bank_b_d;
      row_a_q  <= row_a_d;
      row_b_q  <= row_b_d;
    end
  end

  assign bank_a = bank_a_q;
  assign bank_b = bank_b_q;
  assign row_a  = row_a_q;
  assign row_b  = row_b_q;
endmodule

// File: rtl/rfsh_dual_bank_sched.sv
module rfsh_dual_bank_sched #(
  parameter int  NUM_BANKS       = 8,
  parameter int  SUBARRAYS       = 4,
  parameter int  ROWS_PER_SA     = 8,
  parameter int  WINDOW_NORM_CYC = 2048,
  parameter int  RCW             = 8,
  localparam int BW              = $clog2(NUM_BANKS),
  localparam int RW              = $clog2(ROWS_PER_SA),
  localparam int SAW             = $clog2(SUBARRAYS),
  localparam int BUNDLES         = (NUM_BANKS / 2) * ROWS_PER_SA,
  localparam int REFI_NORM       = WINDOW_NORM_CYC / BUNDLES,
  localparam int REFI_HOT        = REFI_NORM / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 temp_hot,
  input  logic                 mode_dual,
  input  logic [RCW-1:0]       row_cycles,
  input  logic                 req_valid,
  input  logic [BW-1:0]        req_bank,
  output logic                 req_stall,
  output logic [NUM_BANKS-1:0] busy_mask,
  output logic                 refresh_strobe,
  output logic                 refresh_pending,
  output logic [BW-1:0]        grp_a_bank,
  output logic [RW-1:0]        grp_a_row,
  output logic [SUBARRAYS-1:0] grp_a_sa_mask,
  output logic                 grp_b_valid,
  output logic [BW-1:0]        grp_b_bank,
  output logic [RW-1:0]        grp_b_row,
  output logic [SUBARRAYS-1:0] grp_b_sa_mask
);
  localparam int STEPW = SAW + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             due, busy, start, dual_q;
  logic [STEPW-1:0] step;
  logic [BW-1:0]    bank_a, bank_b;
  logic [RW-1:0]    row_a, row_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rfsh_interval_timer #(
    .REFI_NORM (REFI_NORM),
    .REFI_HOT  (REFI_HOT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .temp_hot (temp_hot),
    .due      (due)
  );

  rfsh_busy_engine #(
    .SUBARRAYS (SUBARRAYS),
    .RCW       (RCW)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .due        (due),
    .mode_dual  (mode_dual),
    .row_cycles (row_cycles),
    .busy       (busy),
    .start      (start),
    .strobe     (refresh_strobe),
    .dual_q     (dual_q),
    .step       (step),
    .pending    (refresh_pending)
  );

  rfsh_bank_sequencer #(
    .NUM_BANKS   (NUM_BANKS),
    .ROWS_PER_SA (ROWS_PER_SA)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .mode_dual (mode_dual),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .row_a     (row_a),
    .row_b     (row_b)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_busy
    assign busy_mask[g] = busy && ((bank_a == BW'(g)) || (dual_q && (bank_b == BW'(g))));
  end

  for (genvar s = 0; s < SUBARRAYS; s++) begin : g_sa
    assign grp_a_sa_mask[s] = busy && (dual_q || (step[SAW-1:0] == SAW'(s)));
    assign grp_b_sa_mask[s] = busy && dual_q;
  end

  always_comb begin
    grp_b_valid = busy && dual_q;
    grp_a_bank  = busy ? bank_a : '0;
    grp_b_bank  = grp_b_valid ? bank_b : '0;
    grp_b_row   = grp_b_valid ? row_b : '0;
    if (!busy)       grp_a_row = '0;
    else if (dual_q) grp_a_row = row_a;
    else             grp_a_row = row_a + RW'(step[SAW]);
    req_stall   = req_valid && busy_mask[req_bank];
  end
endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker #(
  parameter int NUM_BANKS = 8,
  parameter int SUBARRAYS = 4,
  parameter int BW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 refresh_strobe,
  input logic                 refresh_pending,
  input logic [NUM_BANKS-1:0] busy_mask,
  input logic                 grp_b_valid,
  input logic [BW-1:0]        grp_a_bank,
  input logic [BW-1:0]        grp_b_bank,
  input logic [SUBARRAYS-1:0] grp_a_sa_mask,
  input logic [SUBARRAYS-1:0] grp_b_sa_mask,
  input logic                 req_stall,
  input logic [BW-1:0]        req_bank
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_strobe |=> !refresh_strobe); // R10
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_strobe |-> (busy_mask != '0)); // R10
  AST_BUSY_BEGINS_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|busy_mask) |-> refresh_strobe); // R10
  AST_TWO_BANK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mask != '0) |-> ($countones(busy_mask) == (grp_b_valid ? 2 : 1))); // R5
  AST_DUAL_SA_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    grp_b_valid |-> ((&grp_a_sa_mask) && (&grp_b_sa_mask))); // R4
  AST_PB_ONE_SUBARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_mask != '0) && !grp_b_valid) |-> ($countones(grp_a_sa_mask) == 1)); // R6
  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    grp_b_valid |-> (!grp_a_bank[0] && (grp_b_bank == grp_a_bank + 1'b1))); // R3
  AST_STALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> ((req_bank == grp_a_bank) || (grp_b_valid && (req_bank == grp_b_bank)))); // R8
  AST_PENDING_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_pending) |-> $past(busy_mask != '0)); // R9
endmodule

bind rfsh_dual_bank_sched rfsh_sched_checker #(
  .NUM_BANKS (NUM_BANKS),
  .SUBARRAYS (SUBARRAYS),
  .BW        (BW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .refresh_strobe  (refresh_strobe),
  .refresh_pending (refresh_pending),
  .busy_mask       (busy_mask),
  .grp_b_valid     (grp_b_valid),
  .grp_a_bank      (grp_a_bank),
  .grp_b_bank      (grp_b_bank),
  .grp_a_sa_mask   (grp_a_sa_mask),
  .grp_b_sa_mask   (grp_b_sa_mask),
  .req_stall       (req_stall),
  .req_bank        (req_bank)
);

// File: tb/rfsh_dual_bank_sched_test.sv
module rfsh_dual_bank_sched_test;
  localparam int NB = 8;
  localparam int SA = 4;
  localparam int RPS = 8;

  typedef struct {
    bit dual;
    int a, b, ra, rb, rc, len;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       temp_hot = 1'b0;
  logic       mode_dual = 1'b1;
  logic [7:0] row_cycles = 8'd5;
  logic       req_valid = 1'b0;
  logic [2:0] req_bank = 3'd0;
  logic       req_stall, refresh_strobe, refresh_pending, grp_b_valid;
  logic [7:0] busy_mask;
  logic [2:0] grp_a_bank, grp_b_bank, grp_a_row, grp_b_row;
  logic [3:0] grp_a_sa_mask, grp_b_sa_mask;

  int checks = 0, failures = 0, cyc = 0;
  exp_t q[$];
  int rp[NB];
  int pidx = 0, bidx = 0;
  bit mon_on = 0, chk_int = 0, have_last = 0;
  int exp_int = 64, last_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfsh_dual_bank_sched uut (
    .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .mode_dual(mode_dual),
    .row_cycles(row_cycles), .req_valid(req_valid), .req_bank(req_bank),
    .req_stall(req_stall), .busy_mask(busy_mask), .refresh_strobe(refresh_strobe),
    .refresh_pending(refresh_pending), .grp_a_bank(grp_a_bank), .grp_a_row(grp_a_row),
    .grp_a_sa_mask(grp_a_sa_mask), .grp_b_valid(grp_b_valid), .grp_b_bank(grp_b_bank),
    .grp_b_row(grp_b_row), .grp_b_sa_mask(grp_b_sa_mask));

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actv, expv, cyc);
    end
  endtask

  // driver: predicts the next n commands from the requirements
  task automatic push_cmds(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int rc;
      rc = (row_cycles == 0) ? 1 : int'(row_cycles);
      e.dual = mode_dual;
      e.rc = rc;
      if (mode_dual) begin
        e.a = 2 * pidx; e.b = 2 * pidx + 1;
        e.ra = rp[e.a]; e.rb = rp[e.b];
        rp[e.a] = (rp[e.a] + 1) % RPS; rp[e.b] = (rp[e.b] + 1) % RPS;   // R7
        pidx = (pidx + 1) % (NB / 2);                                     // R3
        e.len = rc;                                                        // R4
      end else begin
        e.a = bidx; e.b = 0; e.ra = rp[bidx]; e.rb = 0;
        rp[bidx] = (rp[bidx] + 2) % RPS;                                   // R7
        bidx = (bidx + 1) % NB;                                            // R6
        e.len = 2 * SA * rc;
      end
      q.push_back(e);
    end
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // request sweep across banks
  initial begin
    forever begin
      @(posedge clk); #1;
      req_bank = req_bank + 3'd1;
    end
  end

  // monitor: pops expected commands and compares each cycle
  bit   act = 0;
  int   c = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (mon_on) begin
      bit [7:0] em;
      int st, er, es;
      if (refresh_strobe) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected strobe", 1, 0);
        end else begin
          cur = q.pop_front();
          act = 1; c = 0;
          chk(grp_a_bank == cur.a[2:0], cur.dual ? "R3 bank_a" : "R6 bank", grp_a_bank, cur.a);
          chk(grp_b_valid == cur.dual, "R3 grp_b_valid", grp_b_valid, cur.dual);
          if (cur.dual) begin
            chk(grp_b_bank == cur.b[2:0], "R3 bank_b", grp_b_bank, cur.b);
            chk(grp_b_row == cur.rb[2:0], "R7 row_b", grp_b_row, cur.rb);
          end
          if (chk_int && have_last) chk(cyc - last_cyc == exp_int, "R1 interval", cyc - last_cyc, exp_int);
        end
        last_cyc = cyc; have_last = 1;
      end
      em = '0;
      if (act && c < cur.len) begin
        em[cur.a] = 1'b1;
        if (cur.dual) em[cur.b] = 1'b1;
        st = c / cur.rc;
        if (cur.dual) begin
          er = cur.ra; es = 15;
        end else begin
          er = (cur.ra + st / SA) % RPS; es = 1 << (st % SA);
        end
        if (grp_a_row != er[2:0]) chk(1'b0, cur.dual ? "R4 row_a" : "R6 row_a", grp_a_row, er);
        if (grp_a_sa_mask != es[3:0]) chk(1'b0, cur.dual ? "R4 sa_mask" : "R6 sa_mask", grp_a_sa_mask, es);
        if (cur.dual && grp_b_sa_mask != 4'hF) chk(1'b0, "R4 sa_mask_b", grp_b_sa_mask, 15);
      end else begin
        act = 0;
      end
      if (busy_mask != em) chk(1'b0, "R5 busy_mask", busy_mask, em);
      if (req_stall != (req_valid && em[req_bank])) chk(1'b0, "R8 req_stall", req_stall, req_valid && em[req_bank]);
      c++;
    end
  end

  initial begin
    int t0, gap;
    for (int i = 0; i < NB; i++) rp[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(busy_mask == 0, "R11 busy_mask in reset", busy_mask, 0);
    chk(refresh_strobe == 0, "R11 strobe in reset", refresh_strobe, 0);
    chk(refresh_pending == 0, "R11 pending in reset", refresh_pending, 0);
    rst_n = 1'b1;
    req_valid = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(busy_mask == 0 && grp_b_valid == 0, "R11 idle after reset", busy_mask, 0);
    chk(req_stall == 0, "R11 no stall after reset", req_stall, 0);
    mon_on = 1;

    // dual mode, more than one window so pointers wrap (R3 R4 R7 R1)
    mode_dual = 1'b1; row_cycles = 8'd5; exp_int = 64; chk_int = 1;
    push_cmds(40);
    wait_drain();
    checks += 40;

    // per-bank sequential mode (R6)
    mode_dual = 1'b0; row_cycles = 8'd2;
    push_cmds(10);
    wait_drain();
    checks += 10;

    // back to dual with row_cycles 0 treated as 1 (R4 R7)
    mode_dual = 1'b1; row_cycles = 8'd0;
    push_cmds(4);
    wait_drain();

    // hot flag mid-interval (R2 R1)
    chk_int = 0; row_cycles = 8'd5;
    push_cmds(4);
    do @(negedge clk); while (!refresh_strobe);
    repeat (10) @(posedge clk);
    #1;
    temp_hot = 1'b1; t0 = cyc;
    do @(negedge clk); while (!refresh_strobe);
    chk(cyc - t0 == 33, "R2 hot reload", cyc - t0, 33);
    @(posedge clk); #1;
    exp_int = 32; chk_int = 1;
    wait_drain();

    // refresh overrun: pending and one idle cycle (R9)
    chk_int = 0; mode_dual = 1'b0; row_cycles = 8'd40;
    push_cmds(3);
    t0 = 0;
    while (!refresh_pending && t0 < 2000) begin @(negedge clk); t0++; end
    chk(refresh_pending == 1, "R9 pending raised", refresh_pending, 1);
    while (busy_mask != 0) @(negedge clk);
    gap = 0;
    while (busy_mask == 0 && gap < 100) begin gap++; @(negedge clk); end
    chk(gap == 1, "R9 idle gap", gap, 1);
    chk(refresh_strobe == 1, "R9 strobe after gap", refresh_strobe, 1);
    chk(refresh_pending == 0, "R9 pending cleared", refresh_pending, 0);
    wait_drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule